// File: doc/BRIEF.md
# Staggered Double-Rate Integer Add/Logic Unit

This unit performs 32-bit integer add, subtract and bitwise logic on a fast clock that runs at twice the core rate. No operation is finished in a single fast cycle. The result is built in three slices on successive fast cycles. The bottom 16 bits come first. The top 16 bits follow, using the carry registered by the bottom slice. The condition flags come last, formed from the complete 32-bit word. As a result, no fast-cycle path holds more than one 16-bit adder and its operand selects.

A new operation may be issued on every fast cycle, and the unit never stalls. Each operand has its own bypass select. When the select is set, that operand takes the result of the operation issued on the previous fast cycle instead of the value on the port. The bottom half of that result is delivered to the bottom slice of the new operation on the cycle after it was made. The top half reaches the new operation's top slice one cycle later, so the stagger stays aligned. This lets a chain of dependent operations run at one per fast cycle.

Top module: `stagger_alu`

## Requirements
- R1: While rst_ni is low and until the first operation is issued, lo_valid_o, hi_valid_o and flag_valid_o are all 0.
- R2: For an operation issued with valid_i high at fast edge t, lo_valid_o is 1 after edge t. At that point lo_o holds bits 15:0 of the result.
- R3: After edge t+1, hi_valid_o is 1 and hi_o holds bits 31:16 of the result. For arithmetic codes this includes the carry out of the bottom slice.
- R4: Op code 1 gives a - b modulo 2^32, formed as a + ~b + 1.
- R5: Op codes 2, 3 and 4 give a AND b, a OR b and a XOR b. Op code 0 and codes 5 to 7 give a + b.
- R6: After edge t+2, flag_valid_o is 1 and flags_o holds the flags of the full 32-bit result. Bit 0 is zero. Bit 1 is the carry out of bit 31; for subtract it is 1 when there is no borrow. Bit 2 is the sign, equal to bit 31. Bit 3 is signed overflow. The logic codes 2 to 4 force bits 1 and 3 to 0.
- R7: word_o holds the full 32-bit result in the same cycle as flag_valid_o.
- R8: When a_fwd_i (or b_fwd_i) is 1, operand a (or b) is the full result of the operation issued on the previous fast cycle, and the matching operand port is ignored. Chains of dependent operations issued on consecutive cycles give correct results.
- R9: Operations issued on consecutive fast cycles are all accepted. Each one produces its three slices in issue order, with no gaps between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock (twice the core rate) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Issue strobe |
| op_i | input | 3 | Operation code |
| a_i | input | 32 | Operand a |
| b_i | input | 32 | Operand b |
| a_fwd_i | input | 1 | Take operand a from the previous operation's result |
| b_fwd_i | input | 1 | Take operand b from the previous operation's result |
| lo_valid_o | output | 1 | Bottom-half result strobe |
| lo_o | output | 16 | Result bits 15:0 |
| hi_valid_o | output | 1 | Top-half result strobe |
| hi_o | output | 16 | Result bits 31:16 |
| flag_valid_o | output | 1 | Flag strobe |
| flags_o | output | 4 | {overflow, sign, carry, zero} |
| word_o | output | 32 | Full result, aligned with the flags |

## Verification
The assertions assume one thing about the inputs: a bypass select is raised only when an operation was issued on the fast cycle just before. Without that predecessor, the forwarded value would be stale. The stimulus keeps to this rule. Both the directed and the random phases set a_fwd_i or b_fwd_i only when the previous cycle carried an issue. The random phase also inserts bubbles, so that the rule is tested on both sides of a gap.

// File: rtl/stagger_alu_pkg.sv
package stagger_alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_OR  = 3'd3,
    OP_XOR = 3'd4
  } alu_op_e;

  localparam int FLAG_W = 4;
  localparam int FLG_Z  = 0;
  localparam int FLG_C  = 1;
  localparam int FLG_N  = 2;
  localparam int FLG_V  = 3;

  function automatic logic op_is_sub(logic [2:0] op);
    return op == OP_SUB;
  endfunction

  function automatic logic op_is_logic(logic [2:0] op);
    return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
  endfunction

endpackage

// File: rtl/byp_mux.sv
module byp_mux #(
  parameter int W = 16
) (
  input  logic         sel_i,
  input  logic [W-1:0] fwd_i,
  input  logic [W-1:0] port_i,
  output logic [W-1:0] opnd_o
);
  assign opnd_o = sel_i ? fwd_i : port_i;
endmodule

// File: rtl/alu_slice.sv
module alu_slice
  import stagger_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [2:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] r_o,
  output logic         cout_o
);
  logic [W-1:0] b_eff;
  logic [W:0]   sum;

  assign b_eff = op_is_sub(op_i) ? ~b_i : b_i;
  assign sum   = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, cin_i};

  always_comb begin
    unique case (op_i)
      OP_AND:  r_o = a_i & b_i;
      OP_OR:   r_o = a_i | b_i;
      OP_XOR:  r_o = a_i ^ b_i;
      default: r_o = sum[W-1:0];
    endcase
  end

  assign cout_o = op_is_logic(op_i) ? 1'b0 : sum[W];
endmodule

// File: rtl/flag_unit.sv
module flag_unit
  import stagger_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [2:0]        op_i,
  input  logic [W-1:0]      res_i,
  input  logic              cout_i,
  input  logic              a_msb_i,
  input  logic              b_msb_i,
  output logic [FLAG_W-1:0] flags_o
);
  logic arith;
  assign arith = !op_is_logic(op_i);

  always_comb begin
    flags_o        = '0;
    flags_o[FLG_Z] = (res_i == '0);
    flags_o[FLG_C] = arith & cout_i;
    flags_o[FLG_N] = res_i[W-1];
    // b_msb_i is the msb after subtract inversion
    flags_o[FLG_V] = arith & (a_msb_i == b_msb_i) & (res_i[W-1] != a_msb_i);
  end
endmodule

// File: rtl/stagger_alu.sv
module stagger_alu
  import stagger_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [2:0]          op_i,
  input  logic [DATA_W-1:0]   a_i,
  input  logic [DATA_W-1:0]   b_i,
  input  logic                a_fwd_i,
  input  logic                b_fwd_i,
  output logic                lo_valid_o,
  output logic [DATA_W/2-1:0] lo_o,
  output logic                hi_valid_o,
  output logic [DATA_W/2-1:0] hi_o,
  output logic                flag_valid_o,
  output logic [FLAG_W-1:0]   flags_o,
  output logic [DATA_W-1:0]   word_o
);
  localparam int HALF_W = DATA_W / 2;

  // ---------------- stage 1: bottom slice ----------------
  logic [HALF_W-1:0] lo_a, lo_b, lo_r;
  logic              lo_c;
  logic              lv_q, lc_q, fa_h_q, fb_h_q;
  logic [HALF_W-1:0] lo_q, ah_q, bh_q;
  logic [2:0]        op_h_q;

  // stage 2 state declared early: forwarded into stage 2 mux
  logic              hv_q, hc_q, am_q, bm_q;
  logic [HALF_W-1:0] hi_q, lo_h_q;
  logic [2:0]        op_f_q;

  byp_mux #(.W(HALF_W)) u_lo_a (.sel_i(a_fwd_i), .fwd_i(lo_q), .port_i(a_i[HALF_W-1:0]), .opnd_o(lo_a));
  byp_mux #(.W(HALF_W)) u_lo_b (.sel_i(b_fwd_i), .fwd_i(lo_q), .port_i(b_i[HALF_W-1:0]), .opnd_o(lo_b));

  alu_slice #(.W(HALF_W)) u_lo_slice (
    .op_i  (op_i),
    .a_i   (lo_a),
    .b_i   (lo_b),
    .cin_i (op_is_sub(op_i)),
    .r_o   (lo_r),
    .cout_o(lo_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lv_q   <= 1'b0;
      lo_q   <= '0;
      lc_q   <= 1'b0;
      op_h_q <= '0;
      ah_q   <= '0;
      bh_q   <= '0;
      fa_h_q <= 1'b0;
      fb_h_q <= 1'b0;
    end else begin
      lv_q   <= valid_i;
      lo_q   <= lo_r;
      lc_q   <= lo_c;
      op_h_q <= op_i;
      ah_q   <= a_i[DATA_W-1:HALF_W];
      bh_q   <= b_i[DATA_W-1:HALF_W];
      fa_h_q <= a_fwd_i;
      fb_h_q <= b_fwd_i;
    end
  end

  // ---------------- stage 2: top slice ----------------
  logic [HALF_W-1:0] hi_a, hi_b, hi_r;
  logic              hi_c;

  // top half of the predecessor lands in hi_q exactly when this op needs it
  byp_mux #(.W(HALF_W)) u_hi_a (.sel_i(fa_h_q), .fwd_i(hi_q), .port_i(ah_q), .opnd_o(hi_a));
  byp_mux #(.W(HALF_W)) u_hi_b (.sel_i(fb_h_q), .fwd_i(hi_q), .port_i(bh_q), .opnd_o(hi_b));

  alu_slice #(.W(HALF_W)) u_hi_slice (
    .op_i  (op_h_q),
    .a_i   (hi_a),
    .b_i   (hi_b),
    .cin_i (lc_q),
    .r_o   (hi_r),
    .cout_o(hi_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hv_q   <= 1'b0;
      hi_q   <= '0;
      hc_q   <= 1'b0;
      lo_h_q <= '0;
      op_f_q <= '0;
      am_q   <= 1'b0;
      bm_q   <= 1'b0;
    end else begin
      hv_q   <= lv_q;
      hi_q   <= hi_r;
      hc_q   <= hi_c;
      lo_h_q <= lo_q;
      op_f_q <= op_h_q;
      am_q   <= hi_a[HALF_W-1];
      bm_q   <= hi_b[HALF_W-1] ^ op_is_sub(op_h_q);
    end
  end

  // ---------------- stage 3: flags ----------------
  logic [DATA_W-1:0] full_res;
  logic [FLAG_W-1:0] flg_d;
  logic              fv_q;
  logic [FLAG_W-1:0] flg_q;
  logic [DATA_W-1:0] word_q;

  assign full_res = {hi_q, lo_h_q};

  flag_unit #(.W(DATA_W)) u_flags (
    .op_i   (op_f_q),
    .res_i  (full_res),
    .cout_i (hc_q),
    .a_msb_i(am_q),
    .b_msb_i(bm_q),
    .flags_o(flg_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fv_q   <= 1'b0;
      flg_q  <= '0;
      word_q <= '0;
    end else begin
      fv_q   <= hv_q;
      flg_q  <= flg_d;
      word_q <= full_res;
    end
  end

  assign lo_valid_o   = lv_q;
  assign lo_o         = lo_q;
  assign hi_valid_o   = hv_q;
  assign hi_o         = hi_q;
  assign flag_valid_o = fv_q;
  assign flags_o      = flg_q;
  assign word_o       = word_q;

  // ---------------- assertions ----------------
  // input rule: a bypass needs a predecessor issued one cycle earlier
  p_fwd_has_src_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (a_fwd_i || b_fwd_i)) |-> lo_valid_o);

  p_hi_follows_lo_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_valid_o |=> hi_valid_o);

  p_flag_follows_hi_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_valid_o |=> flag_valid_o);

  p_word_lo_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lo_valid_o && hi_valid_o) |=> ##1 (word_o[HALF_W-1:0] == $past(lo_o, 2)));

  p_word_hi_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_valid_o |=> (word_o[DATA_W-1:HALF_W] == $past(hi_o)));

  p_sign_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_valid_o |-> (flags_o[FLG_N] == word_o[DATA_W-1]));

  p_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_valid_o |-> (flags_o[FLG_Z] == (word_o == '0)));

  p_logic_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_valid_o && op_is_logic(op_f_q)) |=> (!flags_o[FLG_C] && !flags_o[FLG_V]));

endmodule

// File: tb/sim_stagger_alu.sv
`timescale 1ns/1ps
module sim_stagger_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [2:0]  op = '0;
  logic [31:0] a = '0, b = '0;
  logic        fa = 1'b0, fb = 1'b0;
  logic        lo_v, hi_v, fl_v;
  logic [15:0] lo, hi;
  logic [3:0]  flags;
  logic [31:0] word;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 0;

  // history of issued ops: index 0 = most recent edge
  logic        h_v   [3];
  logic [31:0] h_res [3];
  logic [3:0]  h_flg [3];
  string       h_tag [3];

  always #2.5 clk = ~clk;

  stagger_alu u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op), .a_i(a), .b_i(b),
    .a_fwd_i(fa), .b_fwd_i(fb), .lo_valid_o(lo_v), .lo_o(lo), .hi_valid_o(hi_v),
    .hi_o(hi), .flag_valid_o(fl_v), .flags_o(flags), .word_o(word)
  );

  // reference: flags = {ovf, sign, carry, zero}
  function automatic logic [35:0] ref_op(logic [2:0] o, logic [31:0] x, logic [31:0] y);
    logic [32:0] s;
    logic [31:0] r;
    logic c, v;
    c = 1'b0; v = 1'b0; s = '0;
    case (o)
      3'd2: r = x & y;
      3'd3: r = x | y;
      3'd4: r = x ^ y;
      3'd1: begin
        s = {1'b0, x} + {1'b0, ~y} + 33'd1;
        r = s[31:0]; c = s[32];
        v = (x[31] != y[31]) && (r[31] != x[31]);
      end
      default: begin
        s = {1'b0, x} + {1'b0, y};
        r = s[31:0]; c = s[32];
        v = (x[31] == y[31]) && (r[31] != x[31]);
      end
    endcase
    return {v, r[31], c, (r == 32'd0), r};
  endfunction

  function automatic string tag_of(logic [2:0] o, logic f);
    string t;
    case (o)
      3'd1: t = "R4";
      3'd2, 3'd3, 3'd4, 3'd5, 3'd6, 3'd7: t = "R5";
      default: t = "R2";
    endcase
    if (f) t = {t, "/R8"};
    return t;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic check_outputs();
    chk({"R2/R9 lo_valid ", h_tag[0]}, 64'(lo_v), 64'(h_v[0]));
    if (h_v[0]) chk({"R2 lo ", h_tag[0]}, 64'(lo), 64'(h_res[0][15:0]));
    chk({"R3/R9 hi_valid ", h_tag[1]}, 64'(hi_v), 64'(h_v[1]));
    if (h_v[1]) chk({"R3 hi ", h_tag[1]}, 64'(hi), 64'(h_res[1][31:16]));
    chk({"R6/R9 flag_valid ", h_tag[2]}, 64'(fl_v), 64'(h_v[2]));
    if (h_v[2]) begin
      chk({"R6 flags ", h_tag[2]}, 64'(flags), 64'(h_flg[2]));
      chk({"R7 word ", h_tag[2]}, 64'(word), 64'(h_res[2]));
    end
  endtask

  task automatic step(logic v, logic [2:0] o, logic [31:0] x, logic [31:0] y, logic sa, logic sb);
    logic [35:0] e;
    logic [31:0] xe, ye;
    @(negedge clk);
    check_outputs();
    valid = v; op = o; a = x; b = y; fa = sa; fb = sb;
    xe = sa ? h_res[0] : x;
    ye = sb ? h_res[0] : y;
    e = ref_op(o, xe, ye);
    @(posedge clk);
    for (int i = 2; i > 0; i--) begin
      h_v[i] = h_v[i-1]; h_res[i] = h_res[i-1]; h_flg[i] = h_flg[i-1]; h_tag[i] = h_tag[i-1];
    end
    h_v[0] = v; h_res[0] = e[31:0]; h_flg[0] = e[35:32]; h_tag[0] = tag_of(o, sa | sb);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 3; i++) begin
      h_v[i] = 1'b0; h_res[i] = '0; h_flg[i] = '0; h_tag[i] = "R1";
    end
    // R1: reset state
    repeat (3) begin
      @(negedge clk);
      chk("R1 lo_valid", 64'(lo_v), 64'd0);
      chk("R1 hi_valid", 64'(hi_v), 64'd0);
      chk("R1 flag_valid", 64'(fl_v), 64'd0);
    end
    rst_n = 1'b1;
    step(0, 0, 0, 0, 0, 0);

    // directed corners
    step(1, 3'd0, 32'h0000_FFFF, 32'h0000_0001, 0, 0); // R3 carry across halves
    step(1, 3'd0, 32'hFFFF_FFFF, 32'h0000_0001, 0, 0); // R6 zero + carry
    step(1, 3'd0, 32'h7FFF_FFFF, 32'h0000_0001, 0, 0); // R6 overflow
    step(1, 3'd1, 32'h1234_5678, 32'h1234_5678, 0, 0); // R4 equal -> zero, carry 1
    step(1, 3'd1, 32'h0000_0000, 32'h0000_0001, 0, 0); // R4 borrow
    step(1, 3'd1, 32'h8000_0000, 32'h0000_0001, 0, 0); // R4 overflow
    step(1, 3'd2, 32'hF0F0_FFFF, 32'hFF00_0F0F, 0, 0); // R5
    step(1, 3'd3, 32'hF0F0_0000, 32'h0F00_0001, 0, 0); // R5
    step(1, 3'd4, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0); // R5 zero, no carry
    step(1, 3'd6, 32'h0000_8000, 32'h0000_8000, 0, 0); // R5 code 6 adds
    // R8: dependent chain, one per cycle
    step(1, 3'd0, 32'h0000_FFFF, 32'h0000_0001, 0, 0);
    step(1, 3'd0, 32'hDEAD_BEEF, 32'h0000_FFFF, 1, 0);
    step(1, 3'd1, 32'h0001_0000, 32'hAAAA_AAAA, 0, 1);
    step(1, 3'd4, 32'h5555_5555, 32'h1111_1111, 1, 1);
    step(1, 3'd0, 32'h0BAD_F00D, 32'h8000_0000, 1, 0);
    step(0, 3'd0, 32'h0, 32'h0, 0, 0);
    step(1, 3'd0, 32'h8000_0000, 32'h8000_0000, 0, 0);
    step(1, 3'd1, 32'hFFFF_FFFF, 32'h0, 0, 1);

    // random phase with bubbles; bypass only after an issue
    for (int n = 0; n < 3000; n++) begin
      logic v;
      logic [2:0] o;
      v = ($urandom_range(0, 9) < 8);
      o = 3'($urandom_range(0, 7));
      step(v, o, $urandom, $urandom,
           v && h_v[0] && $urandom_range(0, 1) == 1,
           v && h_v[0] && $urandom_range(0, 2) == 0);
    end
    repeat (4) step(0, 0, 0, 0, 0, 0);
    finish_run();
  end
endmodule